// File: doc/BRIEF.md
# I2C SCL Rate Generator

This block derives the serial-clock timing of an I2C master from the peripheral clock. Two programmable counters run in cascade: a small prescaler of 1 to 4 and a divider of 1 to 64. Together they produce a base tick. A bit period always spans 22 base ticks. The SCL frequency is therefore the input clock divided by 22·(A+1)·(B+1), where A and B are the two field values. The block can never produce an SCL faster than the input clock divided by 22.

A bit engine uses the four single-cycle phase strobes the block emits in each bit period. One strobe marks the point to pull SCL low, one the point to change SDA, one the point to release SCL, and one the point to sample SDA. The block also outputs the raw SCL level those strobes imply. The low and high halves each last 11 base ticks. The divider fields are meant to be set while the generator is idle. A change made while it runs is held off until the end of the current bit period, so a period never mixes two rates.

Top module: `scl_rate_gen`

## Requirements
- R1: While `run_en` is low, and after reset, all four strobes are 0 and `scl_out` is 1.
- R2: On the first clock edge that samples `run_en` high after it was low, `tick_fall` pulses and `scl_out` goes to 0 in the same cycle.
- R3: Successive `tick_fall` pulses are 22·(A+1)·(B+1) cycles apart, with A = `pre_div` and B = `main_div`.
- R4: With M = (A+1)·(B+1) and `tick_fall` at cycle t, `tick_shift` pulses at t+5M, `tick_rise` at t+11M and `tick_sample` at t+16M. `scl_out` is 0 from t to t+11M and 1 from t+11M to t+22M.
- R5: Each strobe is high for exactly one cycle, and no two strobes are high in the same cycle.
- R6: A change of `pre_div` or `main_div` while running does not alter the current bit period. The new values apply from the next `tick_fall` on.
- R7: Dropping `run_en` clears the strobes and sets `scl_out` to 1 on the next edge. No strobe appears while `run_en` stays low. Raising it again restarts at a fresh period as in R2.
- R8: The field extremes hold: A=0, B=0 gives a 22-cycle period, and A=3, B=63 gives a 5632-cycle period.
- R9: Two `tick_fall` pulses within one enabled stretch are never closer than 22 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Runs the generator when high; clears and idles it when low |
| pre_div | input | 2 | Prescaler field A, divides by A+1 |
| main_div | input | 6 | Divider field B, divides by B+1 |
| scl_out | output | 1 | Raw SCL level (1 = released) |
| tick_fall | output | 1 | Strobe: drive SCL low, start of bit period |
| tick_shift | output | 1 | Strobe: SDA may change |
| tick_rise | output | 1 | Strobe: release SCL |
| tick_sample | output | 1 | Strobe: sample SDA |

## Verification
The bench builds the block with its default parameters: a 2-bit prescaler field, a 6-bit divider field, 22 ticks per bit, the shift point 5 ticks in and the sample point 5 ticks after the rise. With these values both field extremes are cheap to reach. The fastest setting repeats every 22 cycles, and the slowest (A=3, B=63) completes a full 5632-cycle period well inside the run budget. Mixed settings such as A=1, B=2 show that the two stages multiply rather than add. A switch from M=2 to M=12 in mid-period exposes any early reload.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

    // One flag per phase point inside an SCL bit period.
    typedef struct packed {
        logic sample;
        logic rise;
        logic shift;
        logic fall;
    } scl_strobes_t;

endpackage

// File: rtl/scl_count_stage.sv
// One programmable divide-by-(limit+1) stage. It advances only when step_in is high
// and emits step_out on the step that wraps it.
module scl_count_stage #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step_in,
    input  logic [CNT_W-1:0] limit,
    output logic             step_out
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } stage_t;

    stage_t st_d, st_q;
    logic   at_end;

    always_comb begin
        st_d   = st_q;
        at_end = (st_q.cnt == limit);
        if (clr) begin
            st_d.cnt = '0;
        end else if (step_in) begin
            st_d.cnt = at_end ? '0 : CNT_W'(st_q.cnt + 1'b1);
        end
    end

    assign step_out = step_in && !clr && at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6: limits reload only at a wrap, so the count never passes its limit
    a_r6_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= limit)
        else $error("stage count above its limit");

endmodule

// File: rtl/scl_phase_seq.sv
// Counts base ticks across one bit period and issues the phase strobes and the SCL level.
module scl_phase_seq
    import scl_div_pkg::*;
#(
    parameter int BIT_TICKS         = 22,
    parameter int SHIFT_AT          = 5,
    parameter int SAMPLE_AFTER_RISE = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         start,
    input  logic         tick,
    output logic         wrap,
    output logic         scl,
    output scl_strobes_t stb
);

    localparam int T_W       = $clog2(BIT_TICKS);
    localparam int RISE_AT   = BIT_TICKS / 2;
    localparam int SAMPLE_AT = RISE_AT + SAMPLE_AFTER_RISE;
    localparam int LAST      = BIT_TICKS - 1;
    localparam int GAP_W     = $clog2(BIT_TICKS) + 1;

    typedef struct packed {
        logic [T_W-1:0] t;
        logic           scl;
        scl_strobes_t   stb;
    } seq_t;

    seq_t           sq_d, sq_q;
    logic [T_W-1:0] t_nx;
    logic           at_last;

    always_comb begin
        sq_d     = sq_q;
        sq_d.stb = '0;
        at_last  = (sq_q.t == T_W'(LAST));
        t_nx     = at_last ? '0 : T_W'(sq_q.t + 1'b1);
        if (!run) begin
            sq_d.t   = '0;
            sq_d.scl = 1'b1;
        end else if (start) begin
            sq_d.t        = '0;
            sq_d.stb.fall = 1'b1;
            sq_d.scl      = 1'b0;
        end else if (tick) begin
            sq_d.t          = t_nx;
            sq_d.stb.fall   = (t_nx == '0);
            sq_d.stb.shift  = (t_nx == T_W'(SHIFT_AT));
            sq_d.stb.rise   = (t_nx == T_W'(RISE_AT));
            sq_d.stb.sample = (t_nx == T_W'(SAMPLE_AT));
            if (sq_d.stb.fall) sq_d.scl = 1'b0;
            if (sq_d.stb.rise) sq_d.scl = 1'b1;
        end
    end

    assign wrap = run && !start && tick && at_last;
    assign scl  = sq_q.scl;
    assign stb  = sq_q.stb;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q     <= '0;
            sq_q.scl <= 1'b1;
        end else begin
            sq_q <= sq_d;
        end
    end

    // Spacing monitor for the minimum-period property.
    logic [GAP_W-1:0] gap_q;
    logic             seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            if (sq_q.stb.fall) begin
                gap_q <= GAP_W'(1);
            end else if (gap_q != '1) begin
                gap_q <= GAP_W'(gap_q + 1'b1);
            end
            if (!run) begin
                seen_q <= 1'b0;
            end else if (sq_q.stb.fall) begin
                seen_q <= 1'b1;
            end
        end
    end

    a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sq_q.stb))
        else $error("two phase strobes at once");

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (sq_q.scl && sq_q.stb == '0))
        else $error("activity while disabled");

    a_r4_scl_low_with_fall: assert property (@(posedge clk) disable iff (!rst_n)
        sq_q.stb.fall |-> !sq_q.scl)
        else $error("scl not low at fall strobe");

    a_r4_scl_high_with_rise: assert property (@(posedge clk) disable iff (!rst_n)
        sq_q.stb.rise |-> sq_q.scl)
        else $error("scl not high at rise strobe");

    a_r9_min_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.stb.fall && seen_q) |-> (gap_q >= GAP_W'(BIT_TICKS)))
        else $error("bit period shorter than the fixed tick count");

endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
    import scl_div_pkg::*;
#(
    parameter int A_W               = 2,
    parameter int B_W               = 6,
    parameter int BIT_TICKS         = 22,
    parameter int SHIFT_AT          = 5,
    parameter int SAMPLE_AFTER_RISE = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run_en,
    input  logic [A_W-1:0] pre_div,
    input  logic [B_W-1:0] main_div,
    output logic           scl_out,
    output logic           tick_fall,
    output logic           tick_shift,
    output logic           tick_rise,
    output logic           tick_sample
);

    typedef struct packed {
        logic           running;
        logic [A_W-1:0] a_lim;
        logic [B_W-1:0] b_lim;
    } ctl_t;

    ctl_t         ct_d, ct_q;
    logic         start;
    logic         cnt_run;
    logic         a_step;
    logic         base_tick;
    logic         wrap;
    scl_strobes_t stb;

    always_comb begin
        ct_d         = ct_q;
        ct_d.running = run_en;
        start        = run_en && !ct_q.running;
        cnt_run      = run_en && ct_q.running;
        // Fields are taken while idle, at the start edge, or at a period boundary.
        if (!run_en || start || wrap) begin
            ct_d.a_lim = pre_div;
            ct_d.b_lim = main_div;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ct_q <= '0;
        end else begin
            ct_q <= ct_d;
        end
    end

    scl_count_stage #(.CNT_W(A_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!cnt_run),
        .step_in  (cnt_run),
        .limit    (ct_q.a_lim),
        .step_out (a_step)
    );

    scl_count_stage #(.CNT_W(B_W)) u_main (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!cnt_run),
        .step_in  (a_step),
        .limit    (ct_q.b_lim),
        .step_out (base_tick)
    );

    scl_phase_seq #(
        .BIT_TICKS         (BIT_TICKS),
        .SHIFT_AT          (SHIFT_AT),
        .SAMPLE_AFTER_RISE (SAMPLE_AFTER_RISE)
    ) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_en),
        .start (start),
        .tick  (base_tick),
        .wrap  (wrap),
        .scl   (scl_out),
        .stb   (stb)
    );

    assign tick_fall   = stb.fall;
    assign tick_shift  = stb.shift;
    assign tick_rise   = stb.rise;
    assign tick_sample = stb.sample;

    a_r2_fall_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !ct_q.running) |=> (tick_fall && !scl_out))
        else $error("no fall strobe after enable");

endmodule

// File: tb/tb_scl_rate_gen.sv
module tb_scl_rate_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic [1:0] pre_div = '0;
    logic [5:0] main_div = '0;
    logic       scl_out, tick_fall, tick_shift, tick_rise, tick_sample;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    int multi_hits = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz
    always @(posedge clk) cyc <= cyc + 1;

    scl_rate_gen #(.A_W(2), .B_W(6), .BIT_TICKS(22), .SHIFT_AT(5), .SAMPLE_AFTER_RISE(5)) dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .pre_div(pre_div), .main_div(main_div),
        .scl_out(scl_out), .tick_fall(tick_fall), .tick_shift(tick_shift),
        .tick_rise(tick_rise), .tick_sample(tick_sample)
    );

    function automatic logic [3:0] strobes();
        return {tick_sample, tick_rise, tick_shift, tick_fall};
    endfunction

    always @(negedge clk) if ($countones(strobes()) > 1) multi_hits++;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // sel: 0 fall, 1 shift, 2 rise, 3 sample. Returns cycle stamp or -1.
    task automatic wait_strobe(input int sel, output int when);
        when = -1;
        for (int i = 0; i < 30000; i++) begin
            @(negedge clk);
            if (strobes()[sel]) begin
                when = cyc;
                return;
            end
        end
    endtask

    task automatic go_idle(input int a, input int b);
        @(negedge clk);
        run_en   = 1'b0;
        pre_div  = 2'(a);
        main_div = 6'(b);
        repeat (3) @(negedge clk);
    endtask

    task automatic scn_period(input int a, input int b, input string req);
        int m, t0, t;
        m = (a + 1) * (b + 1);
        go_idle(a, b);
        run_en = 1'b1;
        @(negedge clk);
        check(tick_fall == 1'b1, "R2", "fall at start", int'(tick_fall), 1);
        check(scl_out == 1'b0, "R2", "scl low at start", int'(scl_out), 0);
        t0 = cyc;
        wait_strobe(1, t);
        check(t - t0 == 5 * m, "R4", "shift offset", t - t0, 5 * m);
        wait_strobe(2, t);
        check(t - t0 == 11 * m, "R4", "rise offset", t - t0, 11 * m);
        check(scl_out == 1'b1, "R4", "scl high at rise", int'(scl_out), 1);
        wait_strobe(3, t);
        check(t - t0 == 16 * m, "R4", "sample offset", t - t0, 16 * m);
        wait_strobe(0, t);
        check(t - t0 == 22 * m, req, "period", t - t0, 22 * m);
        check(t - t0 >= 22, "R9", "period floor", t - t0, 22);
        @(negedge clk);
        check(tick_fall == 1'b0, "R5", "fall width", int'(tick_fall), 0);
    endtask

    task automatic scn_retime();
        int t0, t;
        go_idle(0, 1);          // M = 2
        run_en = 1'b1;
        @(negedge clk);
        t0 = cyc;
        pre_div  = 2'd2;        // M = 12 from the next period
        main_div = 6'd3;
        wait_strobe(0, t);
        check(t - t0 == 44, "R6", "old period kept", t - t0, 44);
        t0 = t;
        wait_strobe(1, t);
        check(t - t0 == 60, "R6", "new shift offset", t - t0, 60);
        wait_strobe(0, t);
        check(t - t0 == 264, "R6", "new period", t - t0, 264);
    endtask

    task automatic scn_stop();
        int t, hits, highs;
        go_idle(1, 1);          // M = 4
        run_en = 1'b1;
        @(negedge clk);
        wait_strobe(1, t);
        run_en = 1'b0;
        @(negedge clk);
        check(strobes() == 4'b0, "R7", "strobes after stop", int'(strobes()), 0);
        check(scl_out == 1'b1, "R7", "scl after stop", int'(scl_out), 1);
        hits = 0;
        highs = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (strobes() != 4'b0) hits++;
            if (scl_out) highs++;
        end
        check(hits == 0, "R7", "strobes while stopped", hits, 0);
        check(highs == 200, "R7", "scl held high", highs, 200);
        run_en = 1'b1;
        @(negedge clk);
        check(tick_fall == 1'b1, "R7", "restart fall", int'(tick_fall), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(strobes() == 4'b0, "R1", "strobes in reset", int'(strobes()), 0);
        check(scl_out == 1'b1, "R1", "scl in reset", int'(scl_out), 1);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(strobes() == 4'b0 && scl_out, "R1", "idle after reset", int'({strobes(), scl_out}), 1);
        scn_period(0, 0, "R8");
        scn_period(1, 2, "R3");
        scn_period(3, 5, "R3");
        scn_period(2, 0, "R3");
        scn_period(3, 63, "R8");
        scn_retime();
        scn_stop();
        check(multi_hits == 0, "R5", "overlapping strobes", multi_hits, 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule